// File: doc/BRIEF.md
# Clock Health Guard

The block supervises the clocks of a device from a trusted low-frequency reference clock. It watches a crystal oscillator clock, the output clock of a PLL and the PLL's lock indicator, and turns a confirmed problem on any of them into the reaction that configuration selects. The possible reactions are an interrupt, a sticky system reset request, or, for the PLL clock only, a failover that switches the system clock back to the crystal and raises an interrupt.

Each monitored clock drives a free-running edge counter in its own domain. At the end of every fixed window, timed by the reference clock, the reference domain sends a toggle request. The monitored domain answers by copying its count into a holding register and toggling an acknowledge. The reference domain compares the returned count with a programmed inclusive range. If no acknowledge comes back before the next window ends, the clock is treated as stopped. The lock input is synchronized and sampled on every reference cycle. Reports are kept in three write-one-to-clear status flags. The interrupt output is formed from those flags.

The block carries no data stream. Every pin is a plain level control or status signal, so there is no valid/ready pairing and no back-pressure.

Top module: `clock_health_guard`

## Requirements
- R1: Rising edges of each monitored clock are counted over windows of 256 reference cycles. A window is faulty when its count is below the programmed minimum, above the programmed maximum (both inclusive bounds), or missing because the clock has stopped.
- R2: The first window is not judged, and a fault takes effect only after two consecutive faulty windows. With bad bounds from reset, no status flag is set 640 reference cycles after reset release, and the flag is set by 900 cycles.
- R3: A confirmed crystal fault sets status bit 0. It also sets the reset request when react_reset_i bit 0 is 1.
- R4: A confirmed PLL clock fault sets status bit 1. When react_reset_i bit 1 is 1, it sets the reset request and leaves sel_xtal_o at 0.
- R5: When react_reset_i bit 1 is 0, a confirmed PLL clock fault drives sel_xtal_o to 1 (system clock taken from the crystal).
- R6: Once sel_xtal_o is 1, it stays 1 even after the PLL clock recovers, until software writes 1 to clr_i bit 1.
- R7: A high-to-low change of the synchronized lock input sets status bit 2, but only after lock has been seen high once since reset. A lock input that stays low from reset sets nothing.
- R8: A loss of lock sets the reset request when react_reset_i bit 2 is 1.
- R9: A 1 on a bit of clr_i clears only that status bit (bit 0 crystal, bit 1 PLL, bit 2 lock). The other bits keep their values.
- R10: irq_o is 1 exactly when some status bit is 1, its irq_en_i bit is 1 and its react_reset_i bit is 0.
- R11: Once reset_req_o is 1, it stays 1 until rst_n is asserted, whatever clr_i does.
- R12: During and right after reset, status_o, irq_o, reset_req_o and sel_xtal_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Trusted reference clock; all control and status logic runs on it |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously to ref_clk |
| xtal_clk | input | 1 | Crystal oscillator clock under watch |
| pll_clk | input | 1 | PLL output clock under watch |
| pll_locked_i | input | 1 | Asynchronous PLL lock indicator |
| xtal_min_i | input | COUNT_W | Lowest acceptable crystal edge count per window |
| xtal_max_i | input | COUNT_W | Highest acceptable crystal edge count per window |
| pll_min_i | input | COUNT_W | Lowest acceptable PLL edge count per window |
| pll_max_i | input | COUNT_W | Highest acceptable PLL edge count per window |
| react_reset_i | input | 3 | Per source: 1 = request reset, 0 = interrupt (PLL: failover plus interrupt) |
| irq_en_i | input | 3 | Per-source interrupt enables |
| clr_i | input | 3 | Write-one-to-clear strobes for the status bits |
| status_o | output | 3 | Sticky flags: bit 0 crystal, bit 1 PLL clock, bit 2 lock loss |
| irq_o | output | 1 | Interrupt request |
| reset_req_o | output | 1 | Sticky system reset request |
| sel_xtal_o | output | 1 | 1 = system clock switched to the crystal |

## Verification
The assertions assume that clr_i, the bounds and the reaction bits are driven synchronously to ref_clk. They also assume that each status flag rises only on a confirmation pulse from the window judges or the lock watcher, and that rst_n is the only way to drop a reset request. The stimulus meets these assumptions by changing configuration only while reset is held or at falling reference edges. It stops and restarts the monitored clocks only as whole-clock gating, so it never glitches them, and it toggles the lock input freely because that input is synchronized. Random trials pick bounds either well inside or well outside the nominal count. Ambiguous counts near a window boundary therefore never decide an expected value.

// File: rtl/chg_pkg.sv
package chg_pkg;
  localparam int NUM_CLK = 2;
  localparam int NUM_SRC = 3;

  typedef enum logic [1:0] {
    SRC_XTAL = 2'd0,
    SRC_PLL  = 2'd1,
    SRC_LOCK = 2'd2
  } fault_src_e;

  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/chg_edge_counter.sv
// Edge counter living in a monitored clock domain. A toggle on req_tgl
// (from the reference domain) snapshots the running count into held_cnt,
// restarts counting and toggles ack_tgl back.
module chg_edge_counter #(
  parameter int COUNT_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               mon_clk,
  input  logic               arst_n,
  input  logic               req_tgl,
  output logic               ack_tgl,
  output logic [COUNT_W-1:0] held_cnt
);
  localparam logic [COUNT_W-1:0] CNT_SAT = '1;

  logic [1:0]             rst_pipe;
  logic                   mrst_n;
  logic [SYNC_STAGES:0]   req_pipe;
  logic                   req_edge;
  logic [COUNT_W-1:0]     run_cnt;

  always_ff @(posedge mon_clk or negedge arst_n) begin
    if (!arst_n) rst_pipe <= '0;
    else         rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign mrst_n = rst_pipe[1];

  always_ff @(posedge mon_clk or negedge mrst_n) begin
    if (!mrst_n) req_pipe <= '0;
    else         req_pipe <= {req_pipe[SYNC_STAGES-1:0], req_tgl};
  end
  assign req_edge = req_pipe[SYNC_STAGES] ^ req_pipe[SYNC_STAGES-1];

  always_ff @(posedge mon_clk or negedge mrst_n) begin
    if (!mrst_n) begin
      run_cnt  <= '0;
      held_cnt <= '0;
      ack_tgl  <= 1'b0;
    end else begin
      if (req_edge) begin
        held_cnt <= run_cnt;
        run_cnt  <= COUNT_W'(1);
        ack_tgl  <= ~ack_tgl;
      end else if (run_cnt != CNT_SAT) begin
        run_cnt  <= run_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/chg_window_judge.sv
// Reference-domain judge: receives the count over the toggle handshake,
// checks it against the bounds at each window end and confirms a fault
// after two faulty windows in a row.
module chg_window_judge #(
  parameter int COUNT_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               ref_clk,
  input  logic               rst_n,
  input  logic               win_end,
  input  logic               eval_en,
  input  logic               ack_tgl,
  input  logic [COUNT_W-1:0] held_cnt,
  input  logic [COUNT_W-1:0] lo_bound,
  input  logic [COUNT_W-1:0] hi_bound,
  output logic               confirm
);
  logic [SYNC_STAGES:0] ack_pipe;
  logic                 ack_edge;
  logic                 fresh;
  logic [COUNT_W-1:0]   cap_cnt;
  logic [COUNT_W-1:0]   cur_cnt;
  logic                 got_cnt;
  logic                 bad_win;
  logic                 strike;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) ack_pipe <= '0;
    else        ack_pipe <= {ack_pipe[SYNC_STAGES-1:0], ack_tgl};
  end
  assign ack_edge = ack_pipe[SYNC_STAGES] ^ ack_pipe[SYNC_STAGES-1];

  assign cur_cnt = ack_edge ? held_cnt : cap_cnt;
  assign got_cnt = fresh | ack_edge;
  assign bad_win = !got_cnt || (cur_cnt < lo_bound) || (cur_cnt > hi_bound);

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_cnt <= '0;
      fresh   <= 1'b0;
      strike  <= 1'b0;
      confirm <= 1'b0;
    end else begin
      if (ack_edge) cap_cnt <= held_cnt;
      if (win_end)       fresh <= 1'b0;
      else if (ack_edge) fresh <= 1'b1;
      confirm <= 1'b0;
      if (win_end) begin
        if (eval_en) begin
          strike  <= bad_win;
          confirm <= bad_win & strike;
        end else begin
          strike  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/chg_lock_watch.sv
// Synchronizes the lock indicator and flags a drop once lock was seen.
module chg_lock_watch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic lock_async,
  output logic lock_seen,
  output logic loss_evt
);
  logic [SYNC_STAGES-1:0] lk_pipe;
  logic                   lock_s;
  logic                   lock_prev;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) lk_pipe <= '0;
    else        lk_pipe <= {lk_pipe[SYNC_STAGES-2:0], lock_async};
  end
  assign lock_s = lk_pipe[SYNC_STAGES-1];

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_prev <= 1'b0;
      lock_seen <= 1'b0;
      loss_evt  <= 1'b0;
    end else begin
      lock_prev <= lock_s;
      lock_seen <= lock_seen | lock_s;
      loss_evt  <= lock_seen & lock_prev & ~lock_s;
    end
  end
endmodule

// File: rtl/clock_health_guard.sv
module clock_health_guard
  import chg_pkg::*;
#(
  parameter int COUNT_W     = 16,
  parameter int WINDOW_LOG2 = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               ref_clk,
  input  logic               rst_n,
  input  logic               xtal_clk,
  input  logic               pll_clk,
  input  logic               pll_locked_i,
  input  logic [COUNT_W-1:0] xtal_min_i,
  input  logic [COUNT_W-1:0] xtal_max_i,
  input  logic [COUNT_W-1:0] pll_min_i,
  input  logic [COUNT_W-1:0] pll_max_i,
  input  logic [2:0]         react_reset_i,
  input  logic [2:0]         irq_en_i,
  input  logic [2:0]         clr_i,
  output logic [2:0]         status_o,
  output logic               irq_o,
  output logic               reset_req_o,
  output logic               sel_xtal_o
);
  logic [WINDOW_LOG2-1:0]              win_ctr;
  logic                                win_end;
  logic                                first_done;
  logic                                req_tgl;
  logic [NUM_CLK-1:0]                  mon_clk;
  logic [NUM_CLK-1:0][COUNT_W-1:0]     lo_b, hi_b, held;
  logic [NUM_CLK-1:0]                  ack;
  logic [NUM_CLK-1:0]                  confirm;
  logic                                lock_seen;
  logic                                loss_evt;
  src_vec_t                            evt;
  src_vec_t                            status_q;
  logic                                reset_q;
  logic                                sel_q;

  assign mon_clk = {pll_clk, xtal_clk};
  assign lo_b    = {pll_min_i, xtal_min_i};
  assign hi_b    = {pll_max_i, xtal_max_i};

  // Window timer in the reference domain.
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      win_ctr    <= '0;
      first_done <= 1'b0;
      req_tgl    <= 1'b0;
    end else begin
      win_ctr <= win_ctr + 1'b1;
      if (win_end) begin
        first_done <= 1'b1;
        req_tgl    <= ~req_tgl;
      end
    end
  end
  assign win_end = &win_ctr;

  for (genvar g = 0; g < NUM_CLK; g++) begin : g_mon
    chg_edge_counter #(.COUNT_W(COUNT_W), .SYNC_STAGES(SYNC_STAGES)) u_cnt (
      .mon_clk  (mon_clk[g]),
      .arst_n   (rst_n),
      .req_tgl  (req_tgl),
      .ack_tgl  (ack[g]),
      .held_cnt (held[g])
    );
    chg_window_judge #(.COUNT_W(COUNT_W), .SYNC_STAGES(SYNC_STAGES)) u_judge (
      .ref_clk  (ref_clk),
      .rst_n    (rst_n),
      .win_end  (win_end),
      .eval_en  (first_done),
      .ack_tgl  (ack[g]),
      .held_cnt (held[g]),
      .lo_bound (lo_b[g]),
      .hi_bound (hi_b[g]),
      .confirm  (confirm[g])
    );
  end

  chg_lock_watch #(.SYNC_STAGES(SYNC_STAGES)) u_lock (
    .ref_clk    (ref_clk),
    .rst_n      (rst_n),
    .lock_async (pll_locked_i),
    .lock_seen  (lock_seen),
    .loss_evt   (loss_evt)
  );

  assign evt[SRC_XTAL] = confirm[0];
  assign evt[SRC_PLL]  = confirm[1];
  assign evt[SRC_LOCK] = loss_evt;

  // Reactions: sticky flags, sticky reset request, sticky failover.
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      reset_q  <= 1'b0;
      sel_q    <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr_i) | evt;
      reset_q  <= reset_q | (|(evt & react_reset_i));
      sel_q    <= (sel_q & ~clr_i[SRC_PLL])
                | (evt[SRC_PLL] & ~react_reset_i[SRC_PLL]);
    end
  end

  assign status_o    = status_q;
  assign reset_req_o = reset_q;
  assign sel_xtal_o  = sel_q;
  assign irq_o       = |(status_q & irq_en_i & ~react_reset_i);
endmodule

// File: rtl/chg_checker.sv
module chg_checker (
  input logic       ref_clk,
  input logic       rst_n,
  input logic [2:0] status_o,
  input logic       irq_o,
  input logic       reset_req_o,
  input logic       sel_xtal_o,
  input logic [2:0] clr_i,
  input logic [2:0] evt,
  input logic       lock_seen
);
  AST_SEL_NEEDS_PLL_FLAG: assert property (@(posedge ref_clk) disable iff (!rst_n)
    sel_xtal_o |-> status_o[1]); // R5
  AST_SEL_HELD_UNTIL_CLEAR: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $fell(sel_xtal_o) |-> $past(clr_i[1])); // R6
  AST_XTAL_FLAG_CAUSE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(status_o[0]) |-> $past(evt[0])); // R3
  AST_PLL_FLAG_CAUSE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(status_o[1]) |-> $past(evt[1])); // R4
  AST_LOSS_AFTER_LOCK: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(status_o[2]) |-> $past(lock_seen)); // R7
  AST_RESET_STICKY: assert property (@(posedge ref_clk) disable iff (!rst_n)
    reset_req_o |=> reset_req_o); // R11
  AST_IRQ_HAS_FLAG: assert property (@(posedge ref_clk) disable iff (!rst_n)
    irq_o |-> (status_o != 3'b000)); // R10
endmodule

bind clock_health_guard chg_checker u_chg_checker (
  .ref_clk     (ref_clk),
  .rst_n       (rst_n),
  .status_o    (status_o),
  .irq_o       (irq_o),
  .reset_req_o (reset_req_o),
  .sel_xtal_o  (sel_xtal_o),
  .clr_i       (clr_i),
  .evt         (evt),
  .lock_seen   (lock_seen)
);

// File: tb/clock_health_guard_bench.sv
`timescale 1ns/1ps
module clock_health_guard_bench;
  localparam int CW      = 16;
  localparam int XT_NOM  = 512;   // 5120 ns window / 10 ns period
  localparam int PL_NOM  = 1280;  // 5120 ns window / 4 ns period

  logic          ref_clk = 1'b0;
  logic          rst_n   = 1'b0;
  logic          xtal_clk = 1'b0, pll_clk = 1'b0;
  logic          xtal_run = 1'b1, pll_run = 1'b1;
  logic          pll_locked_i = 1'b0;
  logic [CW-1:0] xtal_min_i, xtal_max_i, pll_min_i, pll_max_i;
  logic [2:0]    react_reset_i = '0, irq_en_i = '0, clr_i = '0;
  logic [2:0]    status_o;
  logic          irq_o, reset_req_o, sel_xtal_o;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #10 ref_clk  = ~ref_clk;
  always #5  xtal_clk = xtal_run ? ~xtal_clk : xtal_clk;
  always #2  pll_clk  = pll_run  ? ~pll_clk  : pll_clk;

  clock_health_guard u_clock_health_guard (
    .ref_clk, .rst_n, .xtal_clk, .pll_clk, .pll_locked_i,
    .xtal_min_i, .xtal_max_i, .pll_min_i, .pll_max_i,
    .react_reset_i, .irq_en_i, .clr_i,
    .status_o, .irq_o, .reset_req_o, .sel_xtal_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic good_bounds();
    xtal_min_i = CW'(XT_NOM - 32); xtal_max_i = CW'(XT_NOM + 32);
    pll_min_i  = CW'(PL_NOM - 64); pll_max_i  = CW'(PL_NOM + 64);
  endtask

  task automatic do_reset();
    @(negedge ref_clk); rst_n = 1'b0; clr_i = '0;
    repeat (4) @(negedge ref_clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic clear(input logic [2:0] m);
    @(negedge ref_clk); clr_i = m;
    @(negedge ref_clk); clr_i = '0;
  endtask

  function automatic logic [2:0] exp_status(input bit xb, input bit pb);
    return {1'b0, pb, xb};
  endfunction
  function automatic logic exp_irq(input logic [2:0] st, input logic [2:0] en, input logic [2:0] md);
    return |(st & en & ~md);
  endfunction
  function automatic logic exp_rst(input logic [2:0] st, input logic [2:0] md);
    return |(st & md);
  endfunction

  initial begin
    void'($urandom(32'd4711));
    good_bounds();
    pll_locked_i = 1'b1;

    // Reset state
    @(negedge ref_clk);
    chk("R12 status in reset", status_o, 3'b000);
    chk("R12 outputs in reset", {irq_o, reset_req_o, sel_xtal_o}, 3'b000);
    do_reset();
    wait_cyc(3);
    chk("R12 outputs after reset", {status_o, irq_o, reset_req_o, sel_xtal_o}, 6'd0);

    // Healthy clocks: nothing reported
    wait_cyc(1200);
    chk("R1 healthy clocks no fault", status_o, 3'b000);

    // Two-window confirmation timing with crystal bounds too high
    xtal_min_i = CW'(XT_NOM + 100); xtal_max_i = CW'(XT_NOM + 200);
    irq_en_i = 3'b001; react_reset_i = 3'b000;
    do_reset();
    wait_cyc(640);
    chk("R2 no action after first bad window", status_o[0], 1'b0);
    wait_cyc(260);
    chk("R2 flag after second bad window", status_o[0], 1'b1);
    chk("R10 irq from crystal flag", irq_o, 1'b1);
    chk("R3 interrupt mode no reset", reset_req_o, 1'b0);

    // Clear one bit only; bounds still bad so keep them consistent first
    good_bounds();
    wait_cyc(600);
    pll_locked_i = 1'b0;       // loss of lock sets bit 2 (lock seen since reset)
    wait_cyc(8);
    chk("R7 loss after lock sets bit2", status_o, 3'b101);
    clear(3'b100);
    wait_cyc(2);
    chk("R9 clear bit2 keeps bit0", status_o, 3'b001);
    clear(3'b001);
    wait_cyc(2);
    chk("R9 clear bit0", status_o, 3'b000);
    chk("R10 irq drops with flags", irq_o, 1'b0);

    // Lock low from reset is ignored
    pll_locked_i = 1'b0;
    do_reset();
    wait_cyc(300);
    chk("R7 lock never seen ignored", status_o[2], 1'b0);
    pll_locked_i = 1'b1;
    wait_cyc(20);
    react_reset_i = 3'b100;
    pll_locked_i = 1'b0;
    wait_cyc(8);
    chk("R8 lock loss reset request", reset_req_o, 1'b1);
    clear(3'b111);
    wait_cyc(50);
    chk("R11 reset request sticky", reset_req_o, 1'b1);
    pll_locked_i = 1'b1;

    // Stopped crystal clock is a fault
    react_reset_i = 3'b001; irq_en_i = 3'b001;
    do_reset();
    wait_cyc(100);
    xtal_run = 1'b0;
    wait_cyc(1100);
    chk("R1 stopped crystal flagged", status_o[0], 1'b1);
    chk("R3 crystal reset mode", reset_req_o, 1'b1);
    chk("R10 no irq in reset mode", irq_o, 1'b0);
    xtal_run = 1'b1;

    // PLL failover and stickiness
    react_reset_i = 3'b000; irq_en_i = 3'b010;
    do_reset();
    wait_cyc(100);
    pll_run = 1'b0;
    wait_cyc(1100);
    chk("R5 failover to crystal", sel_xtal_o, 1'b1);
    chk("R5 pll flag and irq", {status_o[1], irq_o, reset_req_o}, 3'b110);
    pll_run = 1'b1;
    wait_cyc(900);
    chk("R6 failover sticky after recovery", sel_xtal_o, 1'b1);
    clear(3'b010);
    wait_cyc(2);
    chk("R6 failover released by clear", sel_xtal_o, 1'b0);
    chk("R9 pll flag cleared", status_o[1], 1'b0);

    // PLL fault in reset mode
    react_reset_i = 3'b010;
    do_reset();
    wait_cyc(100);
    pll_run = 1'b0;
    wait_cyc(1100);
    chk("R4 pll reset request", {status_o[1], reset_req_o, sel_xtal_o}, 3'b110);
    pll_run = 1'b1;

    // Constrained random trials on bounds, modes and enables
    for (int t = 0; t < 10; t++) begin
      bit xb = $urandom_range(0, 1);
      bit pb = $urandom_range(0, 1);
      logic [2:0] md = 3'($urandom_range(0, 3));
      logic [2:0] en = 3'($urandom_range(0, 7));
      logic [2:0] es;
      good_bounds();
      if (xb) begin
        if ($urandom_range(0, 1)) begin xtal_min_i = CW'(XT_NOM + 64); xtal_max_i = CW'(XT_NOM + 300); end
        else begin xtal_min_i = CW'(XT_NOM - 300); xtal_max_i = CW'(XT_NOM - 64); end
      end
      if (pb) begin
        if ($urandom_range(0, 1)) begin pll_min_i = CW'(PL_NOM + 128); pll_max_i = CW'(PL_NOM + 600); end
        else begin pll_min_i = CW'(PL_NOM - 600); pll_max_i = CW'(PL_NOM - 128); end
      end
      react_reset_i = md; irq_en_i = en;
      do_reset();
      wait_cyc(1100);
      es = exp_status(xb, pb);
      chk("R1 random status", status_o, es);
      chk("R10 random irq", irq_o, exp_irq(es, en, md));
      chk("R3 R4 random reset", reset_req_o, exp_rst(es, md));
      chk("R5 random failover", sel_xtal_o, pb & ~md[1]);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge ref_clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule